// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and the calendar as seven packed-BCD bytes: seconds, minutes, hours (24-hour form), a day-of-week index, day of month, month and a two-digit year. A one-second strobe from an external prescaler advances it. All carries settle in the same clock cycle as the strobe. The calendar knows the length of every month. February gets a 29th day whenever the two-digit year is a multiple of four, and year 00 counts as one of those years. A century flag sits beside the hours. It flips when the year wraps from 99 to 00, but only while its enable flag is set.

A host interface writes any byte through a select-and-data port. A stop flag in the seconds byte freezes all counting. A snapshot strobe copies all seven bytes into a shadow bank, and the host reads that bank one byte at a time, so a multi-byte read returns one coherent time even while the live counters keep moving.

Top module: `bcd_rtc_counter`

## Requirements
- R1: A synchronous reset loads seconds, minutes, hours and year with 8'h00 and day of week, day of month and month with 8'h01. The shadow bank takes the same values and `rd_data_o` becomes 8'h00.
- R2: When the counter is running, each accepted tick adds one to seconds (bits 6:0) in BCD, from 00 to 59. Stepping from 59 returns seconds to 00 and adds one to minutes (bits 6:0), which count 00 to 59 and carry into hours in the same cycle.
- R3: Hours (bits 5:0) count 00 to 23. Stepping from 23 returns hours to 00 and, in that same cycle, advances both the day of month and the day of week.
- R4: Day of week (bits 2:0) goes 1,2,3,4,5,6,7 and then back to 1, advancing only at midnight.
- R5: Day of month restarts at 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. Each restart adds one to the month. Stepping from month 12 returns the month to 01 and adds one to the year, which counts 00 to 99.
- R6: February (month 02) ends at day 29 when the BCD year is a multiple of four, year 00 included, and at day 28 otherwise.
- R7: Hours bit 7 is the century enable and hours bit 6 is the century flag. When the year wraps from 99 to 00, the flag inverts if the enable is 1 and holds if the enable is 0.
- R8: While seconds bit 7 (the stop flag) is 1, ticks change no byte.
- R9: With `wr_en_i` high, `wr_data_i` is stored as given into the byte that `wr_sel_i` picks (0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year). A tick arriving in the same cycle is discarded, and select value 7 changes nothing.
- R10: A written field at or above its upper bound, in valid decimal digits, returns to its lower bound at its next advance and carries into the next field.
- R11: A snapshot strobe copies the seven live bytes, as they were before that edge, into the shadow bank. `rd_data_o` shows shadow entry `rd_sel_i` one cycle later, and select 7 reads 8'h00.
- R12: Bits outside the counted fields keep their value when the counter advances. These are minutes bit 7, day-of-week bits 7:3, day-of-month bits 7:6 and month bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second advance strobe, one cycle wide |
| wr_en_i | input | 1 | Host byte write enable |
| wr_sel_i | input | 3 | Byte select for writes |
| wr_data_i | input | 8 | Byte to store |
| snap_i | input | 1 | Copy the live bytes into the shadow bank |
| rd_sel_i | input | 3 | Shadow byte select |
| rd_data_o | output | 8 | Registered shadow byte |
| sec_o | output | 8 | Live seconds byte, stop flag in bit 7 |
| min_o | output | 8 | Live minutes byte |
| hour_o | output | 8 | Live hours byte with century enable and flag |
| wday_o | output | 8 | Live day-of-week byte |
| mday_o | output | 8 | Live day-of-month byte |
| month_o | output | 8 | Live month byte |
| year_o | output | 8 | Live year byte |

## Verification
The assertions treat a tick as accepted only when no write is present and the stop flag is clear. The seconds-step property only applies while the seconds byte holds valid decimal digits below 59, because values with non-decimal digits fall outside the defined behaviour. The stimulus writes only bytes with digits 0 to 9 and applies every write or strobe for exactly one cycle. It reaches month ends, leap Februaries, year wraps and out-of-range values by writing the bytes just before them, and does not wait for a full day of ticks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W  = 8;
  localparam int NFIELD  = 7;
  localparam int SEL_W   = 3;

  localparam int IX_SEC  = 0;
  localparam int IX_MIN  = 1;
  localparam int IX_HOUR = 2;
  localparam int IX_WDAY = 3;
  localparam int IX_MDAY = 4;
  localparam int IX_MON  = 5;
  localparam int IX_YEAR = 6;

  localparam int HALT_BIT = 7;
  localparam int CEN_BIT  = 7;
  localparam int CFLG_BIT = 6;

  // byte i lives at [8*i +: 8]: year, month, mday, wday, hour, min, sec
  localparam logic [NFIELD*BYTE_W-1:0] RESET_IMAGE =
    {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step #(
  parameter int NDIG = 2,
  localparam int VW = 4 * NDIG
) (
  input  logic [VW-1:0] val_i,
  input  logic [VW-1:0] lo_i,
  input  logic [VW-1:0] hi_i,
  input  logic          en_i,
  output logic [VW-1:0] nxt_o,
  output logic          wrap_o
);
  logic [VW-1:0] inc;

  always_comb begin
    logic carry;
    carry = 1'b1;
    inc   = val_i;
    for (int d = 0; d < NDIG; d++) begin
      if (carry) begin
        if (val_i[4*d +: 4] == 4'd9) begin
          inc[4*d +: 4] = 4'd0;
        end else begin
          inc[4*d +: 4] = val_i[4*d +: 4] + 4'd1;
          carry = 1'b0;
        end
      end
    end
  end

  assign wrap_o = en_i && (val_i >= hi_i);
  assign nxt_o  = wrap_o ? lo_i : (en_i ? inc : val_i);
endmodule

// File: rtl/rtc_month_days.sv
module rtc_month_days (
  input  logic [4:0] mon_i,
  input  logic [4:0] yr_lo_i,
  output logic [5:0] last_o
);
  logic leap;

  always_comb begin
    if (yr_lo_i[4])
      leap = (yr_lo_i[3:0] == 4'd2) || (yr_lo_i[3:0] == 4'd6);
    else
      leap = (yr_lo_i[3:0] == 4'd0) || (yr_lo_i[3:0] == 4'd4) ||
             (yr_lo_i[3:0] == 4'd8);
  end

  always_comb begin
    case (mon_i)
      5'h02:                      last_o = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_o = 6'h30;
      default:                    last_o = 6'h31;
    endcase
  end
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow #(
  parameter int NF = 7,
  parameter int W  = 8,
  parameter int SW = 3,
  parameter logic [NF*W-1:0] DEF = '0,
  localparam int DEPTH = 1 << SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snap_i,
  input  logic [NF*W-1:0] live_i,
  input  logic [SW-1:0] rd_sel_i,
  output logic [W-1:0]  rd_data_o
);
  localparam logic [DEPTH*W-1:0] DEF_PAD = (DEPTH*W)'(DEF);

  logic [W-1:0] bank_q [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) bank_q[i] <= DEF_PAD[i*W +: W];
      rd_data_o <= '0;
    end else begin
      rd_data_o <= bank_q[rd_sel_i];
      if (snap_i) begin
        for (int i = 0; i < NF; i++) bank_q[i] <= live_i[i*W +: W];
      end
    end
  end
endmodule

// File: rtl/bcd_rtc_counter.sv
module bcd_rtc_counter
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [7:0]       wr_data_i,
  input  logic             snap_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [7:0]       rd_data_o,
  output logic [7:0]       sec_o,
  output logic [7:0]       min_o,
  output logic [7:0]       hour_o,
  output logic [7:0]       wday_o,
  output logic [7:0]       mday_o,
  output logic [7:0]       month_o,
  output logic [7:0]       year_o
);
  localparam logic [SEL_W-1:0] TOP_SEL = SEL_W'(NFIELD - 1);

  logic [BYTE_W-1:0] tr_q [0:NFIELD-1];
  logic [NFIELD*BYTE_W-1:0] live_flat;

  logic       tick_go;
  logic [7:0] sec_n, min_n, hr_n, md_n, mo_n, yr_n;
  logic [3:0] wd_n;
  logic       sec_w, min_w, hr_w, wd_w, md_w, mo_w, yr_w;
  logic [5:0] last_day;
  logic       unused_pad;

  assign tick_go = tick_i && !wr_en_i && !tr_q[IX_SEC][HALT_BIT];

  rtc_bcd_step #(.NDIG(2)) u_sec (
    .val_i({1'b0, tr_q[IX_SEC][6:0]}), .lo_i(8'h00), .hi_i(8'h59),
    .en_i(tick_go), .nxt_o(sec_n), .wrap_o(sec_w));

  rtc_bcd_step #(.NDIG(2)) u_min (
    .val_i({1'b0, tr_q[IX_MIN][6:0]}), .lo_i(8'h00), .hi_i(8'h59),
    .en_i(sec_w), .nxt_o(min_n), .wrap_o(min_w));

  rtc_bcd_step #(.NDIG(2)) u_hour (
    .val_i({2'b0, tr_q[IX_HOUR][5:0]}), .lo_i(8'h00), .hi_i(8'h23),
    .en_i(min_w), .nxt_o(hr_n), .wrap_o(hr_w));

  rtc_bcd_step #(.NDIG(1)) u_wday (
    .val_i({1'b0, tr_q[IX_WDAY][2:0]}), .lo_i(4'h1), .hi_i(4'h7),
    .en_i(hr_w), .nxt_o(wd_n), .wrap_o(wd_w));

  rtc_month_days u_mlen (
    .mon_i(tr_q[IX_MON][4:0]), .yr_lo_i(tr_q[IX_YEAR][4:0]),
    .last_o(last_day));

  rtc_bcd_step #(.NDIG(2)) u_mday (
    .val_i({2'b0, tr_q[IX_MDAY][5:0]}), .lo_i(8'h01), .hi_i({2'b0, last_day}),
    .en_i(hr_w), .nxt_o(md_n), .wrap_o(md_w));

  rtc_bcd_step #(.NDIG(2)) u_mon (
    .val_i({3'b0, tr_q[IX_MON][4:0]}), .lo_i(8'h01), .hi_i(8'h12),
    .en_i(md_w), .nxt_o(mo_n), .wrap_o(mo_w));

  rtc_bcd_step #(.NDIG(2)) u_year (
    .val_i(tr_q[IX_YEAR]), .lo_i(8'h00), .hi_i(8'h99),
    .en_i(mo_w), .nxt_o(yr_n), .wrap_o(yr_w));

  assign unused_pad = ^{sec_n[7], min_n[7], hr_n[7:6], wd_n[3], wd_w,
                        md_n[7:6], mo_n[7:5]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NFIELD; i++) tr_q[i] <= RESET_IMAGE[i*BYTE_W +: BYTE_W];
    end else if (wr_en_i) begin
      if (wr_sel_i <= TOP_SEL) tr_q[wr_sel_i] <= wr_data_i;
    end else begin
      tr_q[IX_SEC]  <= {tr_q[IX_SEC][7], sec_n[6:0]};
      tr_q[IX_MIN]  <= {tr_q[IX_MIN][7], min_n[6:0]};
      tr_q[IX_HOUR] <= {tr_q[IX_HOUR][CEN_BIT],
                        tr_q[IX_HOUR][CFLG_BIT] ^ (yr_w & tr_q[IX_HOUR][CEN_BIT]),
                        hr_n[5:0]};
      tr_q[IX_WDAY] <= {tr_q[IX_WDAY][7:3], wd_n[2:0]};
      tr_q[IX_MDAY] <= {tr_q[IX_MDAY][7:6], md_n[5:0]};
      tr_q[IX_MON]  <= {tr_q[IX_MON][7:5], mo_n[4:0]};
      tr_q[IX_YEAR] <= yr_n;
    end
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_flat
    assign live_flat[g*BYTE_W +: BYTE_W] = tr_q[g];
  end

  rtc_shadow #(.NF(NFIELD), .W(BYTE_W), .SW(SEL_W), .DEF(RESET_IMAGE)) u_shadow (
    .clk(clk), .rst(rst), .snap_i(snap_i), .live_i(live_flat),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o));

  assign sec_o   = tr_q[IX_SEC];
  assign min_o   = tr_q[IX_MIN];
  assign hour_o  = tr_q[IX_HOUR];
  assign wday_o  = tr_q[IX_WDAY];
  assign mday_o  = tr_q[IX_MDAY];
  assign month_o = tr_q[IX_MON];
  assign year_o  = tr_q[IX_YEAR];
endmodule

// File: rtl/rtc_counter_chk.sv
module rtc_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [2:0] wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] wday_o,
  input logic [7:0] mday_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o
);
  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && sec_o[7]) |=>
      $stable({sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o}));

  // R9
  sec_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_sel_i == 3'd0) |=> (sec_o == $past(wr_data_i)));

  // R9
  year_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_sel_i == 3'd6) |=> (year_o == $past(wr_data_i)));

  // R2
  sec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !wr_en_i && !sec_o[7] && sec_o[3:0] < 4'd9 && sec_o[6:4] < 3'd6) |=>
      (sec_o[3:0] == $past(sec_o[3:0]) + 4'd1));

  // R12
  min_flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> (min_o[7] == $past(min_o[7])));

  // R7
  century_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && !hour_o[7]) |=> (hour_o[7:6] == $past(hour_o[7:6])));
endmodule

bind bcd_rtc_counter rtc_counter_chk u_rtc_chk (.*);

// File: tb/bcd_rtc_counter_bench.sv
module bcd_rtc_counter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0, wr_en_i = 1'b0, snap_i = 1'b0;
  logic [2:0] wr_sel_i = '0, rd_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o, sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string req = "R1";
  logic [7:0] m  [0:6];
  logic [7:0] sh [0:7];
  logic [7:0] exp_rd = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc_counter u_bcd_rtc_counter (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .snap_i(snap_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o), .mday_o(mday_o),
    .month_o(month_o), .year_o(year_o));

  function automatic int bcd2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int month_len(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int adv(input int v, input int lo, input int hi,
                             input bit cin, output bit cout);
    cout = 1'b0;
    if (!cin) return v;
    if (v >= hi) begin cout = 1'b1; return lo; end
    return v + 1;
  endfunction

  task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_edge(input bit tk, input bit we, input logic [2:0] sel,
                            input logic [7:0] dat, input bit sn, input logic [2:0] rs);
    bit c1, c2, c3, c4, c5, c6, cx;
    int s, mi, h, w, d, mo, y, dim;
    logic [7:0] t;
    exp_rd = sh[rs];
    if (sn) for (int i = 0; i < 7; i++) sh[i] = m[i];
    if (we) begin
      if (sel < 3'd7) m[sel] = dat;
    end else if (tk && !m[0][7]) begin
      dim = month_len(bcd2i({3'b0, m[5][4:0]}), bcd2i(m[6]));
      s  = adv(bcd2i({1'b0, m[0][6:0]}), 0, 59, 1'b1, c1);
      mi = adv(bcd2i({1'b0, m[1][6:0]}), 0, 59, c1, c2);
      h  = adv(bcd2i({2'b0, m[2][5:0]}), 0, 23, c2, c3);
      w  = adv(int'(m[3][2:0]), 1, 7, c3, cx);
      d  = adv(bcd2i({2'b0, m[4][5:0]}), 1, dim, c3, c4);
      mo = adv(bcd2i({3'b0, m[5][4:0]}), 1, 12, c4, c5);
      y  = adv(bcd2i(m[6]), 0, 99, c5, c6);
      t = i2bcd(s);  m[0] = {m[0][7], t[6:0]};
      t = i2bcd(mi); m[1] = {m[1][7], t[6:0]};
      t = i2bcd(h);  m[2] = {m[2][7], m[2][6] ^ (c6 & m[2][7]), t[5:0]};
      m[3] = {m[3][7:3], 3'(w)};
      t = i2bcd(d);  m[4] = {m[4][7:6], t[5:0]};
      t = i2bcd(mo); m[5] = {m[5][7:5], t[4:0]};
      m[6] = i2bcd(y);
    end
  endtask

  task automatic compare_all();
    check8({req, " sec"},   sec_o,   m[0]);
    check8({req, " min"},   min_o,   m[1]);
    check8({req, " hour"},  hour_o,  m[2]);
    check8({req, " wday"},  wday_o,  m[3]);
    check8({req, " mday"},  mday_o,  m[4]);
    check8({req, " month"}, month_o, m[5]);
    check8({req, " year"},  year_o,  m[6]);
    check8({req, " rd"},    rd_data_o, exp_rd);
  endtask

  task automatic cyc(input bit tk, input bit we, input logic [2:0] sel,
                     input logic [7:0] dat, input bit sn, input logic [2:0] rs);
    tick_i = tk; wr_en_i = we; wr_sel_i = sel; wr_data_i = dat; snap_i = sn; rd_sel_i = rs;
    @(posedge clk);
    model_edge(tk, we, sel, dat, sn, rs);
    @(negedge clk);
    tick_i = 0; wr_en_i = 0; snap_i = 0;
    compare_all();
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] dat);
    cyc(1'b0, 1'b1, sel, dat, 1'b0, 3'd0);
  endtask

  task automatic tk();
    cyc(1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 3'd0);
  endtask

  task automatic to_midnight(input logic [7:0] hr);
    wr(3'd2, hr); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h01;
    m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00;
    for (int i = 0; i < 7; i++) sh[i] = m[i];
    sh[7] = 8'h00;
    repeat (3) @(negedge clk);
    req = "R1";
    compare_all();
    check8("R1 wday default", wday_o, 8'h01);
    rst = 1'b0;

    req = "R2";
    wr(3'd0, 8'h57);
    repeat (3) tk();
    check8("R2 sec wrap", sec_o, 8'h00);
    check8("R2 min carry", min_o, 8'h01);
    for (int i = 0; i < 300; i++) cyc(1'(i % 3 != 0), 1'b0, 3'd0, 8'h00, 1'b0, 3'd0);

    req = "R3";
    wr(3'd3, 8'h07); wr(3'd4, 8'h10);
    to_midnight(8'h23);
    tk();
    check8("R3 hour wrap", hour_o, 8'h00);
    check8("R3 mday step", mday_o, 8'h11);
    req = "R4";
    check8("R4 wday 7 to 1", wday_o, 8'h01);
    to_midnight(8'h23); tk();
    check8("R4 wday 1 to 2", wday_o, 8'h02);

    req = "R5";
    wr(3'd5, 8'h04); wr(3'd4, 8'h30); to_midnight(8'h23); tk();
    check8("R5 30-day month", month_o, 8'h05);
    check8("R5 30-day date", mday_o, 8'h01);
    wr(3'd5, 8'h01); wr(3'd4, 8'h30); to_midnight(8'h23); tk();
    check8("R5 31-day month keeps", mday_o, 8'h31);
    wr(3'd5, 8'h12); wr(3'd4, 8'h31); wr(3'd6, 8'h05); to_midnight(8'h23); tk();
    check8("R5 year step", year_o, 8'h06);
    check8("R5 month wrap", month_o, 8'h01);

    req = "R6";
    wr(3'd6, 8'h24); wr(3'd5, 8'h02); wr(3'd4, 8'h28); to_midnight(8'h23); tk();
    check8("R6 leap 29th", mday_o, 8'h29);
    to_midnight(8'h23); tk();
    check8("R6 leap march", month_o, 8'h03);
    wr(3'd6, 8'h23); wr(3'd5, 8'h02); wr(3'd4, 8'h28); to_midnight(8'h23); tk();
    check8("R6 common march", month_o, 8'h03);
    wr(3'd6, 8'h00); wr(3'd5, 8'h02); wr(3'd4, 8'h28); to_midnight(8'h23); tk();
    check8("R6 year 00 leap", mday_o, 8'h29);

    req = "R7";
    wr(3'd6, 8'h99); wr(3'd5, 8'h12); wr(3'd4, 8'h31); to_midnight(8'hA3); tk();
    check8("R7 flag toggles", hour_o, 8'hC0);
    check8("R7 year wrap", year_o, 8'h00);
    wr(3'd6, 8'h99); wr(3'd5, 8'h12); wr(3'd4, 8'h31); to_midnight(8'h63); tk();
    check8("R7 flag holds", hour_o, 8'h40);

    req = "R8";
    wr(3'd0, 8'h90);
    repeat (5) tk();
    check8("R8 halted", sec_o, 8'h90);
    wr(3'd0, 8'h10); tk();
    check8("R8 resumed", sec_o, 8'h11);

    req = "R9";
    cyc(1'b1, 1'b1, 3'd0, 8'h33, 1'b0, 3'd0);
    check8("R9 write beats tick", sec_o, 8'h33);
    cyc(1'b1, 1'b1, 3'd7, 8'hFF, 1'b0, 3'd0);
    check8("R9 select 7 ignored", sec_o, 8'h33);

    req = "R10";
    wr(3'd1, 8'h10); wr(3'd0, 8'h75); tk();
    check8("R10 sec out of range", sec_o, 8'h00);
    check8("R10 carry", min_o, 8'h11);

    req = "R11";
    wr(3'd0, 8'h20);
    cyc(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 3'd0);
    repeat (10) tk();
    cyc(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 3'd0);
    check8("R11 shadow sec", rd_data_o, 8'h20);
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 3'(i));
    cyc(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 3'd7);
    check8("R11 select 7 reads zero", rd_data_o, 8'h00);

    req = "R12";
    wr(3'd2, 8'h05); wr(3'd1, 8'hD9); wr(3'd0, 8'h59); tk();
    check8("R12 flag kept", min_o, 8'h80);
    check8("R12 hour step", hour_o, 8'h06);
    wr(3'd3, 8'hF7); wr(3'd5, 8'hE2); to_midnight(8'h23); tk();
    check8("R12 wday upper kept", wday_o, 8'hF1);

    req = "R2 R5 run";
    wr(3'd1, 8'h00); wr(3'd2, 8'h22); wr(3'd5, 8'h02); wr(3'd4, 8'h27);
    for (int i = 0; i < 4000; i++)
      cyc(1'($urandom_range(0, 3) != 0), 1'b0, 3'd0, 8'h00,
          1'($urandom_range(0, 15) == 0), 3'($urandom_range(0, 7)));

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule